// File: doc/BRIEF.md
# Software Branch Hint Fetch Unit

This unit steers instruction fetch for a small in-order core that has no hardware branch predictor. Software runs a hint instruction ahead of a branch. The hint gives two addresses: where the branch sits and where it will jump. The unit keeps exactly one such hint. As soon as the hint is written, the unit reads a short run of instruction words starting at the jump target into a private hint target buffer. It reads them through a fixed-latency read port.

Each issue cycle, a comparator tests the fetch address against the stored branch address. When the hint is ready and the addresses match, the next fetch address becomes the target. The instruction words after the branch then come from the hint target buffer, with no empty cycle. Once the buffered words run out, fetch goes back to the inline path. A hint is ready only when two things hold: a minimum distance in cycles has passed since it was written, and its buffer is full. A hint stays in place until another hint or a reset replaces it, so one hint serves every trip around a loop.

Execute reports each branch outcome on a resolve port. Two cases cost a fixed redirect penalty: a taken branch that was not hinted, and a hinted branch that turns out not to be taken. The hint entry survives these flushes.

Top module: `hint_fetch_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `fetch_valid`, `fetch_from_hint` and `pf_req` are 0. The first edge with `rst` low issues address `RESET_PC`. With no hint and no resolve, later issues go up by 1 per cycle with no gap, `fetch_from_hint` = 0, and `fetch_word` equals the `inline_word` value sampled at the same edge.
- R2: A hint write (`hint_we` = 1 at an edge) raises `pf_req` for exactly `HTB_DEPTH` consecutive cycles, starting right after that edge. The addresses on `pf_addr` are target, target+1, and so on. After that, `pf_req` returns to 0.
- R3: Suppose a hint is written at edge h and its branch address is issued at edge e. The hint takes effect only if e >= h + MIN_DIST + 1 and all buffer words have returned. Otherwise the issue after the branch is the branch address + 1 from the inline path.
- R4: When a ready hint matches, the next `fetch_valid` cycle follows with no gap. That cycle and the next HTB_DEPTH-1 issues carry addresses target+i with `fetch_from_hint` = 1. Their `fetch_word` is the word read for target+i. The issue after that is target+HTB_DEPTH from the inline path.
- R5: A taken resolve (`rslv_valid`, `rslv_taken` = 1) for a branch that was not hinted holds `fetch_valid` at 0 for exactly PENALTY cycles. The next issue is `rslv_target`, from the inline path.
- R6: A taken resolve for the branch the hint last redirected causes no gap and does not change the fetch sequence.
- R7: A not-taken resolve for the branch the hint last redirected holds `fetch_valid` at 0 for exactly PENALTY cycles. Fetch then restarts at `rslv_pc`+1 from the inline path.
- R8: A hint stays in effect after it has been used and after any redirect. Its branch redirects fetch to the target again every time it is issued.
- R9: A new hint write replaces the old one. The old branch address no longer redirects fetch, and the new one does once it is ready.
- R10: A not-taken resolve for a branch that was not hinted has no effect: the next issue is the previous address + 1 with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hint_we | input | 1 | Hint instruction write strobe |
| hint_br_addr | input | AW | Address of the hinted branch |
| hint_tgt_addr | input | AW | Target address of the hinted branch |
| inline_word | input | IW | Word at the head of the inline prefetch buffer |
| rslv_valid | input | 1 | Branch resolution strobe from execute |
| rslv_taken | input | 1 | Resolved direction, 1 = taken |
| rslv_pc | input | AW | Address of the resolved branch |
| rslv_target | input | AW | Resolved target address |
| pf_req | output | 1 | Target buffer read request |
| pf_addr | output | AW | Target buffer read address |
| pf_rdata | input | IW | Read data, MEM_LAT edges after the request edge |
| fetch_valid | output | 1 | An instruction is issued this cycle |
| fetch_pc | output | AW | Address of the issued instruction |
| fetch_from_hint | output | 1 | 1 when the word came from the hint target buffer |
| fetch_word | output | IW | Issued instruction word |

## Verification
Each test measures the readiness countdown at its edge. A hint placed MIN_DIST+1 issues ahead of its branch must miss, and one placed MIN_DIST+2 ahead must hit. A countdown that is off by one therefore shows up as a wrong address in the issue right after the branch. A fill that goes wrong or is stale shows up in `fetch_word` during the first redirected cycle, because every buffer word is checked against the word read for its address. The bench counts the `fetch_valid` gap cycles after every resolve. A penalty counter that is off, or a mispredict decision that is wrong, therefore shows as a wrong gap length or as an unexpected gap within PENALTY+1 cycles. A hint that is lost after a flush shows on the next pass over the loop branch.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

  // Source of the word issued in a cycle
  typedef enum logic {
    SRC_INLINE = 1'b0,
    SRC_HINT   = 1'b1
  } fetch_src_e;

  // Redirect cause decided from a branch resolution
  typedef enum logic [1:0] {
    RD_NONE       = 2'd0,
    RD_TAKEN_MISS = 2'd1,
    RD_NT_MISS    = 2'd2
  } redir_e;

endpackage

// File: rtl/hfu_hint_entry.sv
module hfu_hint_entry #(
  parameter int AW       = 16,
  parameter int MIN_DIST = 8     // must be at least 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] br_in,
  input  logic [AW-1:0] tgt_in,
  output logic          vld,
  output logic [AW-1:0] br_q,
  output logic [AW-1:0] tgt_q,
  output logic          dist_ok
);

  localparam int DW = $clog2(MIN_DIST + 1);

  logic [DW-1:0] dist_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= 1'b0;
      br_q     <= '0;
      tgt_q    <= '0;
      dist_cnt <= '0;
    end else if (wr) begin
      vld      <= 1'b1;
      br_q     <= br_in;
      tgt_q    <= tgt_in;
      dist_cnt <= DW'(MIN_DIST);
    end else if (dist_cnt != '0) begin
      dist_cnt <= dist_cnt - DW'(1);
    end
  end

  assign dist_ok = (dist_cnt == '0);

  // R8
  hint_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> vld);

  // R3
  dist_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> !dist_ok);

endmodule

// File: rtl/hfu_target_buf.sv
module hfu_target_buf #(
  parameter int AW    = 16,
  parameter int IW    = 32,
  parameter int DEPTH = 4,
  parameter int LAT   = 2,
  localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  tgt,
  output logic           pf_req,
  output logic [AW-1:0]  pf_addr,
  input  logic [IW-1:0]  pf_rdata,
  input  logic [IXW-1:0] rd_idx,
  output logic [IW-1:0]  rd_word,
  output logic           filled
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [IXW-1:0] req_idx;
  logic [LAT-1:0] stg_vld;
  logic [IXW-1:0] stg_idx [LAT];
  logic [CW-1:0]  got_cnt;
  logic [IW-1:0]  words [DEPTH];
  logic           req_last;
  logic           wr_en;

  assign req_last = (req_idx == IXW'(DEPTH - 1));
  assign wr_en    = stg_vld[LAT-1] && !start;

  // Request issue: one address per cycle, DEPTH in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_req  <= 1'b0;
      pf_addr <= '0;
      req_idx <= '0;
    end else if (start) begin
      pf_req  <= 1'b1;
      pf_addr <= tgt;
      req_idx <= '0;
    end else if (pf_req) begin
      pf_addr <= pf_addr + AW'(1);
      req_idx <= req_idx + IXW'(1);
      if (req_last) pf_req <= 1'b0;
    end
  end

  // Return tracking: fixed latency, in-flight words of an older hint dropped
  always_ff @(posedge clk) begin
    if (rst || start) begin
      stg_vld <= '0;
    end else begin
      for (int i = LAT - 1; i > 0; i--) stg_vld[i] <= stg_vld[i-1];
      stg_vld[0] <= pf_req;
    end
    for (int i = LAT - 1; i > 0; i--) stg_idx[i] <= stg_idx[i-1];
    stg_idx[0] <= req_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || start) got_cnt <= '0;
    else if (wr_en)   got_cnt <= got_cnt + CW'(1);
  end

  // Storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) words[stg_idx[LAT-1]] <= pf_rdata;
  end

  assign rd_word = words[rd_idx];
  assign filled  = (got_cnt == CW'(DEPTH));

  // R2
  fill_stop_chk: assert property (@(posedge clk) disable iff (rst)
    filled |-> !pf_req);

  // R2
  fill_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_req && !start && !req_last) |=> (pf_req && pf_addr == $past(pf_addr) + AW'(1)));

endmodule

// File: rtl/hfu_fetch_ctl.sv
module hfu_fetch_ctl
  import hfu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int IW       = 32,
  parameter int DEPTH    = 4,
  parameter int PENALTY  = 12,   // must be at least 1
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int IXW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hint_wr,
  input  logic           hint_rdy,
  input  logic [AW-1:0]  hint_br,
  input  logic [AW-1:0]  hint_tgt,
  input  logic [IW-1:0]  inline_word,
  input  logic [IW-1:0]  buf_word,
  output logic [IXW-1:0] rd_idx,
  input  logic           rslv_valid,
  input  logic           rslv_taken,
  input  logic [AW-1:0]  rslv_pc,
  input  logic [AW-1:0]  rslv_target,
  output logic           fetch_valid,
  output logic [AW-1:0]  fetch_pc,
  output logic           fetch_from_hint,
  output logic [IW-1:0]  fetch_word
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = (PENALTY > 1) ? $clog2(PENALTY) : 1;

  logic [AW-1:0] pc;
  logic [AW-1:0] pred_pc;
  logic          pred_vld;
  logic [SW-1:0] stall;
  logic [CW-1:0] left;
  fetch_src_e    src_q;
  redir_e        redir;
  logic          pred_match;
  logic          issue;
  logic          hit;

  always_comb begin
    pred_match = pred_vld && (rslv_pc == pred_pc);
    redir      = RD_NONE;
    if (rslv_valid) begin
      if (rslv_taken && !pred_match)      redir = RD_TAKEN_MISS;
      else if (!rslv_taken && pred_match) redir = RD_NT_MISS;
    end
    issue = (stall == '0);
    hit   = hint_rdy && (pc == hint_br);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= RESET_PC;
      pred_pc     <= '0;
      pred_vld    <= 1'b0;
      stall       <= '0;
      left        <= '0;
      rd_idx      <= '0;
      src_q       <= SRC_INLINE;
      fetch_valid <= 1'b0;
      fetch_pc    <= '0;
      fetch_word  <= '0;
    end else if (redir != RD_NONE) begin
      pc          <= (redir == RD_TAKEN_MISS) ? rslv_target : rslv_pc + AW'(1);
      stall       <= SW'(PENALTY - 1);
      left        <= '0;
      pred_vld    <= 1'b0;
      src_q       <= SRC_INLINE;
      fetch_valid <= 1'b0;
    end else begin
      if (rslv_valid && pred_match) pred_vld <= 1'b0;
      if (!issue) begin
        stall       <= stall - SW'(1);
        src_q       <= SRC_INLINE;
        fetch_valid <= 1'b0;
      end else begin
        fetch_valid <= 1'b1;
        fetch_pc    <= pc;
        if (left != '0) begin
          src_q      <= SRC_HINT;
          fetch_word <= buf_word;
          rd_idx     <= rd_idx + IXW'(1);
          left       <= left - CW'(1);
        end else begin
          src_q      <= SRC_INLINE;
          fetch_word <= inline_word;
        end
        if (hit) begin
          pc       <= hint_tgt;
          left     <= CW'(DEPTH);
          rd_idx   <= '0;
          pred_vld <= 1'b1;
          pred_pc  <= pc;
        end else begin
          pc <= pc + AW'(1);
        end
      end
      // buffer is being refilled: stop reading it
      if (hint_wr) left <= '0;
    end
  end

  assign fetch_from_hint = (src_q == SRC_HINT);

  // R5 R7
  redirect_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (redir != RD_NONE) |=> !fetch_valid);

  // R4
  hint_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((issue && hit && redir == RD_NONE && !hint_wr) ##1 (redir == RD_NONE))
      |=> (fetch_valid && fetch_from_hint));

  // R6
  taken_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (rslv_valid && rslv_taken && pred_match && issue) |=> fetch_valid);

  // R4
  hint_src_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_from_hint |-> fetch_valid);

endmodule

// File: rtl/hint_fetch_unit.sv
module hint_fetch_unit #(
  parameter int AW        = 16,
  parameter int IW        = 32,
  parameter int HTB_DEPTH = 4,
  parameter int MEM_LAT   = 2,
  parameter int MIN_DIST  = 8,
  parameter int PENALTY   = 12,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hint_we,
  input  logic [AW-1:0] hint_br_addr,
  input  logic [AW-1:0] hint_tgt_addr,
  input  logic [IW-1:0] inline_word,
  input  logic          rslv_valid,
  input  logic          rslv_taken,
  input  logic [AW-1:0] rslv_pc,
  input  logic [AW-1:0] rslv_target,
  output logic          pf_req,
  output logic [AW-1:0] pf_addr,
  input  logic [IW-1:0] pf_rdata,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_from_hint,
  output logic [IW-1:0] fetch_word
);

  localparam int IXW = (HTB_DEPTH > 1) ? $clog2(HTB_DEPTH) : 1;

  logic           h_vld;
  logic [AW-1:0]  h_br;
  logic [AW-1:0]  h_tgt;
  logic           h_dist_ok;
  logic           buf_full;
  logic           h_rdy;
  logic [IXW-1:0] rd_idx;
  logic [IW-1:0]  buf_word;

  assign h_rdy = h_vld && h_dist_ok && buf_full;

  hfu_hint_entry #(
    .AW       (AW),
    .MIN_DIST (MIN_DIST)
  ) u_entry (
    .clk     (clk),
    .rst     (rst),
    .wr      (hint_we),
    .br_in   (hint_br_addr),
    .tgt_in  (hint_tgt_addr),
    .vld     (h_vld),
    .br_q    (h_br),
    .tgt_q   (h_tgt),
    .dist_ok (h_dist_ok)
  );

  hfu_target_buf #(
    .AW    (AW),
    .IW    (IW),
    .DEPTH (HTB_DEPTH),
    .LAT   (MEM_LAT)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .start    (hint_we),
    .tgt      (hint_tgt_addr),
    .pf_req   (pf_req),
    .pf_addr  (pf_addr),
    .pf_rdata (pf_rdata),
    .rd_idx   (rd_idx),
    .rd_word  (buf_word),
    .filled   (buf_full)
  );

  hfu_fetch_ctl #(
    .AW       (AW),
    .IW       (IW),
    .DEPTH    (HTB_DEPTH),
    .PENALTY  (PENALTY),
    .RESET_PC (RESET_PC)
  ) u_ctl (
    .clk             (clk),
    .rst             (rst),
    .hint_wr         (hint_we),
    .hint_rdy        (h_rdy),
    .hint_br         (h_br),
    .hint_tgt        (h_tgt),
    .inline_word     (inline_word),
    .buf_word        (buf_word),
    .rd_idx          (rd_idx),
    .rslv_valid      (rslv_valid),
    .rslv_taken      (rslv_taken),
    .rslv_pc         (rslv_pc),
    .rslv_target     (rslv_target),
    .fetch_valid     (fetch_valid),
    .fetch_pc        (fetch_pc),
    .fetch_from_hint (fetch_from_hint),
    .fetch_word      (fetch_word)
  );

endmodule

// File: tb/hint_fetch_unit_tb_top.sv
module hint_fetch_unit_tb_top;

  localparam int AW       = 16;
  localparam int IW       = 32;
  localparam int DEPTH    = 4;
  localparam int LAT      = 2;
  localparam int MIN_DIST = 8;
  localparam int PENALTY  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hint_we = 1'b0;
  logic [AW-1:0] hint_br_addr = '0;
  logic [AW-1:0] hint_tgt_addr = '0;
  logic [IW-1:0] inline_word = '0;
  logic          rslv_valid = 1'b0;
  logic          rslv_taken = 1'b0;
  logic [AW-1:0] rslv_pc = '0;
  logic [AW-1:0] rslv_target = '0;
  logic          pf_req;
  logic [AW-1:0] pf_addr;
  logic [IW-1:0] pf_rdata;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          fetch_from_hint;
  logic [IW-1:0] fetch_word;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [AW-1:0] last_pc;
  logic          last_src;
  logic [IW-1:0] last_word;
  logic [IW-1:0] last_inl;
  int            last_bub;
  logic [AW-1:0] hb;

  always #10 clk = ~clk;   // 50 MHz

  hint_fetch_unit #(
    .AW (AW), .IW (IW), .HTB_DEPTH (DEPTH), .MEM_LAT (LAT),
    .MIN_DIST (MIN_DIST), .PENALTY (PENALTY), .RESET_PC ('0)
  ) dut_i (
    .clk (clk), .rst (rst),
    .hint_we (hint_we), .hint_br_addr (hint_br_addr), .hint_tgt_addr (hint_tgt_addr),
    .inline_word (inline_word),
    .rslv_valid (rslv_valid), .rslv_taken (rslv_taken),
    .rslv_pc (rslv_pc), .rslv_target (rslv_target),
    .pf_req (pf_req), .pf_addr (pf_addr), .pf_rdata (pf_rdata),
    .fetch_valid (fetch_valid), .fetch_pc (fetch_pc),
    .fetch_from_hint (fetch_from_hint), .fetch_word (fetch_word)
  );

  function automatic logic [IW-1:0] memw(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction

  // fixed-latency read port model
  logic [IW-1:0] mpipe [LAT];
  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) mpipe[i] <= mpipe[i-1];
    mpipe[0] <= pf_req ? memw(pf_addr) : '0;
  end
  assign pf_rdata = mpipe[LAT-1];

  // inline buffer head changes every cycle
  always @(posedge clk) inline_word <= inline_word + 1;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      report();
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Step to the next issued instruction, counting empty cycles before it.
  task automatic next_fetch();
    bit got = 1'b0;
    last_bub = 0;
    for (int k = 0; k < 64 && !got; k++) begin
      @(negedge clk);
      rslv_valid = 1'b0;
      hint_we    = 1'b0;
      if (fetch_valid) begin
        got       = 1'b1;
        last_pc   = fetch_pc;
        last_src  = fetch_from_hint;
        last_word = fetch_word;
        last_inl  = inline_word - 1;
      end else begin
        last_bub++;
      end
    end
  endtask

  task automatic fetch_until(input logic [AW-1:0] a, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 64 && !seen; k++) begin
      next_fetch();
      if (last_pc == a) seen = 1'b1;
    end
    check(seen, req, 64'(last_pc), 64'(a));
  endtask

  task automatic put_hint(input logic [AW-1:0] b, input logic [AW-1:0] t);
    hint_we       = 1'b1;
    hint_br_addr  = b;
    hint_tgt_addr = t;
  endtask

  task automatic put_resolve(input logic tk, input logic [AW-1:0] p, input logic [AW-1:0] t);
    rslv_valid  = 1'b1;
    rslv_taken  = tk;
    rslv_pc     = p;
    rslv_target = t;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(fetch_valid == 1'b0, "R1 valid in reset", 64'(fetch_valid), 0);
    check(pf_req == 1'b0, "R1 pf_req in reset", 64'(pf_req), 0);
    rst = 1'b0;
    next_fetch();
    check(last_bub == 0 && last_pc == '0, "R1 first issue", 64'(last_pc), 0);
    check(last_src == 1'b0 && last_word == last_inl, "R1 inline word", 64'(last_word), 64'(last_inl));
    for (int i = 1; i < 4; i++) begin
      next_fetch();
      check(last_bub == 0 && last_pc == AW'(i), "R1 sequential", 64'(last_pc), 64'(i));
    end
  endtask

  task automatic t_fill();
    next_fetch();
    put_hint(last_pc + 16'd40, 16'h0400);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      hint_we = 1'b0;
      check(pf_req && pf_addr == 16'h0400 + AW'(i), "R2 fill address",
            64'(pf_addr), 64'(16'h0400 + i));
    end
    @(negedge clk);
    check(pf_req == 1'b0, "R2 fill stops", 64'(pf_req), 0);
  endtask

  task automatic t_unhinted_taken();
    put_resolve(1'b1, 16'h0050, 16'h0100);
    next_fetch();
    check(last_bub == PENALTY, "R5 penalty", 64'(last_bub), 64'(PENALTY));
    check(last_pc == 16'h0100 && !last_src, "R5 target", 64'(last_pc), 64'h100);
  endtask

  task automatic t_nt_unhinted();
    logic [AW-1:0] p;
    p = last_pc;
    put_resolve(1'b0, p, 16'h0900);
    next_fetch();
    check(last_bub == 0 && last_pc == p + 16'd1, "R10 no effect", 64'(last_pc), 64'(p + 16'd1));
  endtask

  task automatic t_hint_hit();
    hb = last_pc + 16'd20;
    put_hint(hb, 16'h0200);
    fetch_until(hb, "R4 reach branch");
    for (int i = 0; i < DEPTH; i++) begin
      next_fetch();
      check(last_bub == 0 && last_src && last_pc == 16'h0200 + AW'(i), "R4 hinted issue",
            64'(last_pc), 64'(16'h0200 + i));
      check(last_word == memw(16'h0200 + AW'(i)), "R4 buffer word",
            64'(last_word), 64'(memw(16'h0200 + AW'(i))));
    end
    next_fetch();
    check(!last_src && last_pc == 16'h0204 && last_word == last_inl, "R4 back to inline",
          64'(last_pc), 64'h204);
  endtask

  task automatic t_taken_ok();
    put_resolve(1'b1, hb, 16'h0200);
    next_fetch();
    check(last_bub == 0 && last_pc == 16'h0205, "R6 no bubble", 64'(last_pc), 64'h205);
  endtask

  task automatic t_loop_and_nt();
    put_resolve(1'b1, 16'h0060, hb - 16'd3);
    next_fetch();
    check(last_bub == PENALTY && last_pc == hb - 16'd3, "R5 redirect", 64'(last_pc), 64'(hb - 16'd3));
    fetch_until(hb, "R8 reach branch");
    next_fetch();
    check(last_src && last_pc == 16'h0200 && last_bub == 0, "R8 hit again", 64'(last_pc), 64'h200);
    put_resolve(1'b0, hb, 16'h0200);
    next_fetch();
    check(last_bub == PENALTY, "R7 penalty", 64'(last_bub), 64'(PENALTY));
    check(!last_src && last_pc == hb + 16'd1, "R7 restart", 64'(last_pc), 64'(hb + 16'd1));
    put_resolve(1'b1, 16'h0061, hb - 16'd1);
    fetch_until(hb, "R8 reach after flush");
    next_fetch();
    check(last_src && last_pc == 16'h0200, "R8 survives flush", 64'(last_pc), 64'h200);
  endtask

  task automatic t_replace();
    logic [AW-1:0] b2;
    b2 = last_pc + 16'd30;
    put_hint(b2, 16'h0300);
    put_resolve(1'b1, 16'h0070, hb - 16'd1);
    fetch_until(hb, "R9 reach old branch");
    next_fetch();
    check(!last_src && last_pc == hb + 16'd1, "R9 old hint gone", 64'(last_pc), 64'(hb + 16'd1));
    put_resolve(1'b1, 16'h0071, b2 - 16'd1);
    fetch_until(b2, "R9 reach new branch");
    next_fetch();
    check(last_src && last_pc == 16'h0300, "R9 new hint hits", 64'(last_pc), 64'h300);
  endtask

  task automatic t_distance(input int ahead, input bit expect_hit, input logic [AW-1:0] t);
    logic [AW-1:0] b;
    b = last_pc + AW'(ahead);
    put_hint(b, t);
    fetch_until(b, "R3 reach branch");
    next_fetch();
    if (expect_hit)
      check(last_src && last_pc == t, "R3 ready at distance", 64'(last_pc), 64'(t));
    else
      check(!last_src && last_pc == b + 16'd1, "R3 too close", 64'(last_pc), 64'(b + 16'd1));
  endtask

  initial begin
    t_reset();
    t_fill();
    t_unhinted_taken();
    t_nt_unhinted();
    t_hint_hit();
    t_taken_ok();
    t_loop_and_nt();
    t_replace();
    t_distance(3, 1'b0, 16'h0500);
    t_distance(MIN_DIST + 1, 1'b0, 16'h0600);
    t_distance(MIN_DIST + 2, 1'b1, 16'h0700);
    report();
  end

endmodule